// File: doc/BRIEF.md
# Match Timer with Watchdog Channel

The block keeps a free-running 32-bit up-counter. The counter moves forward by one on each cycle in which the tick-enable input is high, and it wraps from all-ones to zero. Four 32-bit compare registers watch the counter. When a tick carries the counter onto a compare value, that channel has hit. A hit sets the channel's status bit only if the channel's enable bit is set. The set status bit drives the channel's interrupt line as a level, and the level holds until software clears the bit.

The last channel (index 3) also serves as a watchdog. A hit on that channel while bit 0 of the watchdog-arm register is set produces a one-cycle reset-request pulse. The same hit clears the arm register, so the watchdog fires once and then stays disarmed until software arms it again.

Software uses a single-cycle register port: a write strobe, a read strobe, a byte address and 32-bit data. Read data and the error flag are registered.

The register offsets are:

| Offset | Register |
|---|---|
| 0x00, 0x04, 0x08, 0x0C | Compare values for channels 0 to 3 |
| 0x10 | Counter |
| 0x14 | Status (write one to clear) |
| 0x18 | Watchdog arm |
| 0x1C | Channel enables |

Top module: `wdt_match_timer`

## Requirements
- R1: After reset the counter, the four compare values, the status bits, the enable register and the watchdog-arm register all read zero. `irqOut` and `resetReq` are low.
- R2: On each cycle with `tickEn` high and no counter write, the counter adds one modulo 2^32, so 0xFFFFFFFF is followed by 0. With `tickEn` low the counter holds.
- R3: A write to offset 0x10 loads the counter. The load wins over a tick in the same cycle, and a load never counts as a hit, even when the loaded value equals a compare value.
- R4: A channel hits when a tick moves the counter to that channel's compare value. If the channel's enable bit (bit i of offset 0x1C) is set, status bit i (bit i of offset 0x14) and `irqOut[i]` are high from the edge where the counter takes that value.
- R5: A hit on a channel whose enable bit is clear leaves that channel's status bit and interrupt line low.
- R6: A write to offset 0x14 clears exactly the status bits written as 1 and leaves the others alone. Each cleared channel's `irqOut` bit falls at the same edge. Writing 1 to a bit that is already clear has no effect.
- R7: A write to offset 0x1C stores only bits 11:0 of the data. Bits 31:12 read as zero.
- R8: A channel-3 hit while bit 0 of offset 0x18 is set makes `resetReq` high for exactly one cycle and clears offset 0x18 to zero at the same edge. This does not depend on enable bit 3. A channel-3 hit with bit 0 clear gives no pulse.
- R9: A read of any offset outside the map returns zero and raises `regErr` for one cycle. Reads of mapped offsets leave `regErr` low.
- R10: Read data is registered. It is valid in the cycle after `regRdEn` and is zero in cycles that follow no read.
- R11: The compare values at offsets 0x00 to 0x0C and the watchdog-arm register at offset 0x18 read back the full 32 bits that were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Count enable, one count per high cycle |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 8 | Byte offset of the access |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Registered read data |
| regErr | output | 1 | One-cycle flag for a read of an unmapped offset |
| irqOut | output | 4 | Per-channel interrupt levels |
| resetReq | output | 1 | One-cycle watchdog reset request |

## Verification
Every result is due one edge after its cause:
- A counter load, a tick, a status set or clear, and a watchdog pulse are all visible after the clock edge that takes the write or the tick.
- Read data and `regErr` appear after the edge that samples `regRdEn`.

The bench drives inputs on the falling edge and holds them for one rising edge. It samples the outputs on the next falling edge, which is exactly when they become due. For the watchdog, the bench samples `resetReq` after every single tick, so it sees both the pulse and the fact that the pulse lasts one cycle.

// File: rtl/mtm_pkg.sv
package mtm_pkg;
  localparam int MTM_CH = 4;
  localparam int MTM_ADDR_W = 8;

  localparam logic [MTM_ADDR_W-1:0] OFF_MATCH0 = 8'h00;
  localparam logic [MTM_ADDR_W-1:0] OFF_CNT    = 8'h10;
  localparam logic [MTM_ADDR_W-1:0] OFF_STATUS = 8'h14;
  localparam logic [MTM_ADDR_W-1:0] OFF_WDARM  = 8'h18;
  localparam logic [MTM_ADDR_W-1:0] OFF_ENABLE = 8'h1C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MATCH,
    SEL_CNT,
    SEL_STATUS,
    SEL_WDARM,
    SEL_ENABLE
  } rdSel_e;

  typedef struct packed {
    logic [MTM_CH-1:0]         wrMatch;
    logic                      wrCnt;
    logic                      wrStatus;
    logic                      wrWd;
    logic                      wrEnable;
    rdSel_e                    rdSel;
    logic [$clog2(MTM_CH)-1:0] rdIdx;
  } strobe_t;
endpackage

// File: rtl/mtm_ctrl.sv
module mtm_ctrl
  import mtm_pkg::*;
#(
  parameter int ADDR_W = MTM_ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strb,
  output logic              regErr
);
  localparam int IDX_W = $clog2(MTM_CH);

  logic [MTM_CH-1:0] matchAddrHit;
  logic              mapped;

  genvar gi;
  generate
    for (gi = 0; gi < MTM_CH; gi++) begin : g_dec
      assign matchAddrHit[gi] = (regAddr == ADDR_W'(OFF_MATCH0 + 4 * gi));
    end
  endgenerate

  always_comb begin
    mapped = (|matchAddrHit) || regAddr == OFF_CNT || regAddr == OFF_STATUS ||
             regAddr == OFF_WDARM || regAddr == OFF_ENABLE;

    strb.wrMatch  = regWrEn ? matchAddrHit : '0;
    strb.wrCnt    = regWrEn && regAddr == OFF_CNT;
    strb.wrStatus = regWrEn && regAddr == OFF_STATUS;
    strb.wrWd     = regWrEn && regAddr == OFF_WDARM;
    strb.wrEnable = regWrEn && regAddr == OFF_ENABLE;

    strb.rdIdx = '0;
    for (int i = 0; i < MTM_CH; i++) begin
      if (matchAddrHit[i]) strb.rdIdx = IDX_W'(i);
    end

    strb.rdSel = SEL_NONE;
    if (regRdEn) begin
      if (|matchAddrHit)              strb.rdSel = SEL_MATCH;
      else if (regAddr == OFF_CNT)    strb.rdSel = SEL_CNT;
      else if (regAddr == OFF_STATUS) strb.rdSel = SEL_STATUS;
      else if (regAddr == OFF_WDARM)  strb.rdSel = SEL_WDARM;
      else if (regAddr == OFF_ENABLE) strb.rdSel = SEL_ENABLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regErr <= 1'b0;
    else       regErr <= regRdEn && !mapped;
  end
endmodule

// File: rtl/mtm_datapath.sv
module mtm_datapath
  import mtm_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int ENA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  strobe_t           strb,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  cntVal,
  output logic              wdArmed,
  output logic [MTM_CH-1:0] irqOut,
  output logic              resetReq,
  output logic [CNT_W-1:0]  rdData
);
  localparam int WD_CH = MTM_CH - 1;

  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  cntInc;
  logic [CNT_W-1:0]  matchQ [MTM_CH];
  logic [MTM_CH-1:0] hit;
  logic [MTM_CH-1:0] statusQ;
  logic [MTM_CH-1:0] clrMask;
  logic [ENA_W-1:0]  enableQ;
  logic [CNT_W-1:0]  wdQ;
  logic              wdFire;
  logic [CNT_W-1:0]  rdMux;

  assign cntInc = cntQ + CNT_W'(1);

  genvar gi;
  generate
    for (gi = 0; gi < MTM_CH; gi++) begin : g_ch
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                  matchQ[gi] <= '0;
        else if (strb.wrMatch[gi])  matchQ[gi] <= wrData;
      end
      assign hit[gi] = tickEn && !strb.wrCnt && (cntInc == matchQ[gi]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cntQ <= '0;
    else if (strb.wrCnt)  cntQ <= wrData;
    else if (tickEn)      cntQ <= cntInc;
  end

  assign clrMask = strb.wrStatus ? wrData[MTM_CH-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~clrMask) | (hit & enableQ[MTM_CH-1:0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              enableQ <= '0;
    else if (strb.wrEnable) enableQ <= wrData[ENA_W-1:0];
  end

  assign wdFire = hit[WD_CH] && wdQ[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdQ      <= '0;
      resetReq <= 1'b0;
    end else begin
      resetReq <= wdFire;
      if (wdFire)         wdQ <= '0;
      else if (strb.wrWd) wdQ <= wrData;
    end
  end

  always_comb begin
    case (strb.rdSel)
      SEL_MATCH:  rdMux = matchQ[strb.rdIdx];
      SEL_CNT:    rdMux = cntQ;
      SEL_STATUS: rdMux = CNT_W'(statusQ);
      SEL_WDARM:  rdMux = wdQ;
      SEL_ENABLE: rdMux = CNT_W'(enableQ);
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdMux;
  end

  assign cntVal  = cntQ;
  assign wdArmed = wdQ[0];
  assign irqOut  = statusQ;
endmodule

// File: rtl/wdt_match_timer.sv
module wdt_match_timer
  import mtm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ENA_W  = 12,
  parameter int ADDR_W = MTM_ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWrData,
  output logic [CNT_W-1:0]  regRdData,
  output logic              regErr,
  output logic [MTM_CH-1:0] irqOut,
  output logic              resetReq
);
  strobe_t          strb;
  logic [CNT_W-1:0] cntVal;
  logic             wdArmed;

  mtm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .strb(strb), .regErr(regErr)
  );

  mtm_datapath #(.CNT_W(CNT_W), .ENA_W(ENA_W)) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strb(strb), .wrData(regWrData),
    .cntVal(cntVal), .wdArmed(wdArmed), .irqOut(irqOut), .resetReq(resetReq),
    .rdData(regRdData)
  );
endmodule

// File: rtl/mtm_checker.sv
module mtm_checker
  import mtm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = MTM_ADDR_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [CNT_W-1:0]  regWrData,
  input logic              regErr,
  input logic [MTM_CH-1:0] irqOut,
  input logic              resetReq,
  input logic [CNT_W-1:0]  cntVal,
  input logic              wdArmed
);
  logic cntWr;
  logic stWr;

  assign cntWr = regWrEn && regAddr == OFF_CNT;
  assign stWr  = regWrEn && regAddr == OFF_STATUS;

  assert_cnt_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> cntVal == $past(regWrData));

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !cntWr) |=> cntVal == $past(cntVal) + CNT_W'(1));

  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !cntWr) |=> $stable(cntVal));

  assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !stWr |=> (irqOut & $past(irqOut)) == $past(irqOut));

  assert_irq_rise_on_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((irqOut & ~$past(irqOut)) != '0) |-> $past(tickEn));

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  assert_disarm_on_fire_R8: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> !wdArmed);

  assert_err_after_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    regErr |-> $past(regRdEn));
endmodule

bind wdt_match_timer mtm_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .regWrData(regWrData), .regErr(regErr), .irqOut(irqOut),
  .resetReq(resetReq), .cntVal(cntVal), .wdArmed(wdArmed)
);

// File: tb/wdt_match_timer_bench.sv
module wdt_match_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        regErr;
  logic [3:0]  irqOut;
  logic        resetReq;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  wdt_match_timer u_wdt_match_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .regErr(regErr), .irqOut(irqOut), .resetReq(resetReq)
  );

  localparam int NV = 8;
  localparam logic [7:0]  VA [NV] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h1C, 8'h1C, 8'h18, 8'h18};
  localparam logic [31:0] VD [NV] = '{32'h1111_1111, 32'hA5A5_A5A5, 32'h0000_0000, 32'hFFFF_FFFF,
                                      32'hFFFF_FFFF, 32'h0000_1234, 32'h0000_0002, 32'h0000_0000};
  localparam logic [31:0] VE [NV] = '{32'h1111_1111, 32'hA5A5_A5A5, 32'h0000_0000, 32'hFFFF_FFFF,
                                      32'h0000_0FFF, 32'h0000_0234, 32'h0000_0002, 32'h0000_0000};

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic e);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    d = regRdData; e = regErr;
    regRdEn = 1'b0;
  endtask

  task automatic tick(output logic rr);
    tickEn = 1'b1;
    @(negedge clk);
    rr = resetReq;
    tickEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    logic rr;
    for (int i = 0; i < n; i++) tick(rr);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog timeout actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic e;
    logic rr;
    repeat (3) @(negedge clk);
    check("R1 irqOut at reset", 32'(irqOut), 0);
    check("R1 resetReq at reset", 32'(resetReq), 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      rd(8'(a * 4), d, e);
      check($sformatf("R1 reset value at %h", a * 4), d, 0);
    end
    @(negedge clk);
    check("R10 idle read data is zero", regRdData, 0);

    for (int v = 0; v < NV; v++) begin
      wr(VA[v], VD[v]);
      rd(VA[v], d, e);
      check($sformatf("R11/R7 readback vector %0d", v), d, VE[v]);
    end
    wr(8'h1C, 0);
    wr(8'h0C, 0);

    wr(8'h10, 100); ticks(5); rd(8'h10, d, e);
    check("R2 counter after five ticks", d, 105);
    @(negedge clk); rd(8'h10, d, e);
    check("R2 counter holds without tick", d, 105);
    wr(8'h10, 32'hFFFF_FFFE); ticks(3); rd(8'h10, d, e);
    check("R2 counter wraps", d, 1);

    tickEn = 1'b1; wr(8'h10, 50); tickEn = 1'b0; rd(8'h10, d, e);
    check("R3 load wins over tick", d, 50);

    wr(8'h00, 10); wr(8'h04, 7); wr(8'h1C, 32'h1); wr(8'h10, 5);
    ticks(4);
    check("R4 no irq before match", 32'(irqOut), 0);
    ticks(1);
    check("R4 irq0 on match", 32'(irqOut), 32'h1);
    rd(8'h14, d, e);
    check("R5 status only enabled channel", d, 32'h1);

    wr(8'h14, 32'hF);
    check("R6 irq lowered by clear", 32'(irqOut), 0);
    wr(8'h10, 10); rd(8'h14, d, e);
    check("R3 load onto compare value is no hit", d, 0);

    wr(8'h00, 20); wr(8'h08, 20); wr(8'h1C, 32'h5); wr(8'h10, 19);
    ticks(1);
    rd(8'h14, d, e);
    check("R4 two channels hit", d, 32'h5);
    wr(8'h14, 32'h1);
    check("R6 clear one bit irq", 32'(irqOut), 32'h4);
    wr(8'h14, 32'h2);
    rd(8'h14, d, e);
    check("R6 clearing a clear bit is no-op", d, 32'h4);
    wr(8'h14, 32'hF);
    check("R6 clear all", 32'(irqOut), 0);

    wr(8'h1C, 0); wr(8'h0C, 30); wr(8'h18, 32'h1); wr(8'h10, 28);
    tick(rr); check("R8 no pulse before match", 32'(rr), 0);
    tick(rr); check("R8 pulse on channel3 match", 32'(rr), 1);
    @(negedge clk);
    check("R8 pulse lasts one cycle", 32'(resetReq), 0);
    rd(8'h18, d, e);
    check("R8 arm register cleared", d, 0);
    rd(8'h14, d, e);
    check("R5 status3 clear with enable off", d, 0);
    wr(8'h10, 28);
    tick(rr); tick(rr);
    check("R8 disarmed gives no pulse", 32'(rr), 0);
    wr(8'h18, 32'h2); wr(8'h10, 29);
    tick(rr);
    check("R8 bit0 clear gives no pulse", 32'(rr), 0);

    rd(8'h20, d, e);
    check("R9 unmapped read data", d, 0);
    check("R9 unmapped read flag", 32'(e), 1);
    @(negedge clk);
    check("R9 flag is one cycle", 32'(regErr), 0);
    rd(8'h14, d, e);
    check("R9 mapped read no flag", 32'(e), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule